// File: doc/BRIEF.md
# Embedded-Base Register Index Legality Unit

This unit sits in the decode stage of a RISC-V core. It looks at each instruction word and flags it as illegal when the core runs the 16-register embedded base and the instruction names a register at or above x16 in a field it really uses. The flag and a suppress signal are raised combinationally, in the same cycle as the instruction valid strobe. Downstream execute logic can therefore stop every side effect before it happens. A CSR read-write with a high destination index, for example, never reaches the CSR.

The unit also holds the base-selection bits of the misa extension field. The I bit sits at bit 8 and the E bit at bit 4. E always reads as the complement of I. A parameter chooses which bases the core supports. When both are supported, I resets to 1 and software can clear it to enter the embedded base.

Top module: `embx_reg_legality`

## Requirements
- R1: With both bases supported, after reset the I bit reads 1, the E bit reads 0, and no instruction is flagged.
- R2: While the I bit is 1, illegal_o stays low for every instruction.
- R3: In embedded mode, an R-format instruction (opcodes 0110011, 0111011, 0101111) is illegal when bit 4 of rd (instr[11]), rs1 (instr[19]) or rs2 (instr[24]) is set.
- R4: In embedded mode, I-format opcodes (0010011, 0011011, 0000011, 1100111, 0001111, and 1110011 with funct3[2]=0) check rd and rs1, and ignore instr[24:20].
- R5: In embedded mode, S and B formats (0100011, 1100011) check rs1 and rs2, and ignore instr[11:7].
- R6: In embedded mode, U and J formats (0110111, 0010111, 1101111) check only rd, and ignore instr[24:15].
- R7: In embedded mode, CSR immediate forms (opcode 1110011 with funct3[2]=1) check rd but not the rs1 field, which carries an immediate.
- R8: suppress_o equals illegal_o in the same cycle. Both are low whenever instr_valid_i is low.
- R9: With both bases supported, a write sets the I bit from misa_wdata_i[8] and E reads its complement. The new base applies to instructions from the next cycle.
- R10: Opcodes outside the formats above are never flagged.
- R11: With only the embedded base supported, I reads 0 and E reads 1 whatever is written, and the embedded check is always active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_i | input | 32 | Instruction word under decode |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| misa_we_i | input | 1 | Write strobe for the misa extension field |
| misa_wdata_i | input | 32 | misa write data (bit 8 = I) |
| illegal_o | output | 1 | Instruction uses a register index the active base lacks |
| suppress_o | output | 1 | Block all side effects of this instruction |
| misa_i_o | output | 1 | Readable I bit |
| misa_e_o | output | 1 | Readable E bit |

## Verification
Each format is tried with a high index placed in one field at a time, so that every live field and every ignored field is told apart. The same words are presented in both bases, which separates the base gate from the field decode. CSR register and CSR immediate forms share a high rs1 field to tell the funct3 rule apart. A write is followed at once by an instruction, which shows whether the new base takes effect one cycle late or too early. A second instance built for the embedded base alone confirms that writes to the I bit are ignored.

// File: rtl/embx_pkg.sv
package embx_pkg;
  typedef enum logic [1:0] {BASE_I_ONLY, BASE_E_ONLY, BASE_BOTH} base_cfg_e;

  localparam int unsigned ILEN   = 32;
  localparam int unsigned MISA_W = 32;
  localparam int unsigned I_POS  = 8;
  localparam int unsigned RIDX_W = 5;

  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_OP32   = 7'b0111011;
  localparam logic [6:0] OPC_AMO    = 7'b0101111;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OPIM32 = 7'b0011011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_FENCE  = 7'b0001111;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;

  typedef struct packed {
    logic rd;
    logic rs1;
    logic rs2;
  } live_fields_t;
endpackage

// File: rtl/embx_fmt_decode.sv
module embx_fmt_decode
  import embx_pkg::*;
(
  input  logic [6:0]   opcode_i,
  input  logic [2:0]   funct3_i,
  output live_fields_t live_o
);
  always_comb begin
    live_o = '0;
    unique case (opcode_i)
      OPC_OP, OPC_OP32, OPC_AMO:
        live_o = '{rd: 1'b1, rs1: 1'b1, rs2: 1'b1};
      OPC_OPIMM, OPC_OPIM32, OPC_LOAD, OPC_JALR, OPC_FENCE:
        live_o = '{rd: 1'b1, rs1: 1'b1, rs2: 1'b0};
      // CSR immediate forms reuse rs1 as a 5-bit immediate
      OPC_SYSTEM:
        live_o = '{rd: 1'b1, rs1: ~funct3_i[2], rs2: 1'b0};
      OPC_STORE, OPC_BRANCH:
        live_o = '{rd: 1'b0, rs1: 1'b1, rs2: 1'b1};
      OPC_LUI, OPC_AUIPC, OPC_JAL:
        live_o = '{rd: 1'b1, rs1: 1'b0, rs2: 1'b0};
      default: live_o = '0;
    endcase
  end
endmodule

// File: rtl/embx_base_sel.sv
module embx_base_sel
  import embx_pkg::*;
#(
  parameter base_cfg_e SUPPORT = BASE_BOTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MISA_W-1:0] wdata_i,
  output logic              i_bit_o
);
  generate
    if (SUPPORT == BASE_BOTH) begin : g_rw
      logic i_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   i_q <= 1'b1;
        else if (we_i) i_q <= wdata_i[I_POS];
      end
      assign i_bit_o = i_q;

      a_r9_write_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> (i_bit_o == $past(wdata_i[I_POS])));
      a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_i |=> $stable(i_bit_o));
    end else begin : g_fixed
      logic unused_in;
      assign unused_in = ^{clk_i, rst_ni, we_i, wdata_i};
      assign i_bit_o   = (SUPPORT == BASE_I_ONLY);
    end
  endgenerate
endmodule

// File: rtl/embx_field_check.sv
module embx_field_check
  import embx_pkg::*;
(
  input  logic [RIDX_W-1:0] rd_i,
  input  logic [RIDX_W-1:0] rs1_i,
  input  logic [RIDX_W-1:0] rs2_i,
  input  live_fields_t      live_i,
  output logic              high_o
);
  // embedded base has 16 registers: the field MSB must be clear
  localparam int unsigned MSB = RIDX_W - 1;
  assign high_o = (live_i.rd  & rd_i[MSB])
                | (live_i.rs1 & rs1_i[MSB])
                | (live_i.rs2 & rs2_i[MSB]);
endmodule

// File: rtl/embx_reg_legality.sv
module embx_reg_legality
  import embx_pkg::*;
#(
  parameter base_cfg_e SUPPORT = BASE_BOTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ILEN-1:0]   instr_i,
  input  logic              instr_valid_i,
  input  logic              misa_we_i,
  input  logic [MISA_W-1:0] misa_wdata_i,
  output logic              illegal_o,
  output logic              suppress_o,
  output logic              misa_i_o,
  output logic              misa_e_o
);
  live_fields_t live;
  logic         high_idx;
  logic         i_bit;
  logic         unused_bits;

  assign unused_bits = ^instr_i[31:25];

  embx_fmt_decode u_fmt (
    .opcode_i (instr_i[6:0]),
    .funct3_i (instr_i[14:12]),
    .live_o   (live)
  );

  embx_field_check u_chk (
    .rd_i   (instr_i[11:7]),
    .rs1_i  (instr_i[19:15]),
    .rs2_i  (instr_i[24:20]),
    .live_i (live),
    .high_o (high_idx)
  );

  embx_base_sel #(.SUPPORT(SUPPORT)) u_base (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (misa_we_i),
    .wdata_i (misa_wdata_i),
    .i_bit_o (i_bit)
  );

  assign misa_i_o   = i_bit;
  assign misa_e_o   = ~i_bit;
  assign illegal_o  = instr_valid_i & ~i_bit & high_idx;
  assign suppress_o = illegal_o;

  a_r2_i_base_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misa_i_o |-> !illegal_o);
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |-> (!illegal_o && !suppress_o));
  a_r8_suppress_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> suppress_o);
  a_r6_upper_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[6:0] == OPC_LUI && !instr_i[11]) |-> !illegal_o);
  a_r10_unknown_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[6:0] == 7'b1111111) |-> !illegal_o);
endmodule

// File: tb/tb_embx_reg_legality.sv
`timescale 1ns/1ps
module tb_embx_reg_legality;
  import embx_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr = '0;
  logic        valid = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic        ill, sup, mi, me;
  logic        ill_e, sup_e, mi_e, me_e;

  int checks = 0;
  int fails  = 0;
  bit ref_i  = 1'b1;

  always #2 clk = ~clk;

  embx_reg_legality dut (
    .clk_i(clk), .rst_ni(rst_ni), .instr_i(instr), .instr_valid_i(valid),
    .misa_we_i(we), .misa_wdata_i(wdata), .illegal_o(ill), .suppress_o(sup),
    .misa_i_o(mi), .misa_e_o(me));

  embx_reg_legality #(.SUPPORT(BASE_E_ONLY)) dut_e (
    .clk_i(clk), .rst_ni(rst_ni), .instr_i(instr), .instr_valid_i(valid),
    .misa_we_i(we), .misa_wdata_i(wdata), .illegal_o(ill_e), .suppress_o(sup_e),
    .misa_i_o(mi_e), .misa_e_o(me_e));

  function automatic logic [31:0] mk(logic [6:0] opc, int rd, int f3, int rs1, int rs2);
    logic [4:0] a = 5'(rd);
    logic [4:0] b = 5'(rs1);
    logic [4:0] c = 5'(rs2);
    logic [2:0] f = 3'(f3);
    return {7'b0, c, b, f, a, opc};
  endfunction

  // behavioural reference: which register numbers does this opcode read or write
  function automatic bit ref_bad(logic [31:0] w, bit emb);
    int rd  = int'(w[11:7]);
    int rs1 = int'(w[19:15]);
    int rs2 = int'(w[24:20]);
    bit urd, urs1, urs2;
    string k;
    case (w[6:0])
      7'h33, 7'h3b, 7'h2f:             k = "R";
      7'h13, 7'h1b, 7'h03, 7'h67, 7'h0f: k = "I";
      7'h73:                          k = w[14] ? "CI" : "I";
      7'h23, 7'h63:                   k = "SB";
      7'h37, 7'h17, 7'h6f:            k = "UJ";
      default:                        k = "-";
    endcase
    urd  = (k == "R" || k == "I" || k == "CI" || k == "UJ");
    urs1 = (k == "R" || k == "I" || k == "SB");
    urs2 = (k == "R" || k == "SB");
    if (!emb) return 1'b0;
    return (urd && rd > 15) || (urs1 && rs1 > 15) || (urs2 && rs2 > 15);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // present one cycle of stimulus, compare, then let the clock edge update the model
  task automatic step(string req, logic [31:0] w, bit v, bit wr, bit wi);
    bit e;
    @(negedge clk);
    instr = w; valid = v; we = wr; wdata = '0; wdata[8] = wi;
    #1;
    e = v && ref_bad(w, !ref_i);
    chk({req, " illegal"}, ill, e);
    chk({req, " suppress"}, sup, e);
    chk({req, " I"}, mi, ref_i);
    chk({req, " E"}, me, !ref_i);
    @(posedge clk);
    if (wr) ref_i = wi;
  endtask

  task automatic sweep(string req, logic [6:0] opc, int f3);
    step(req, mk(opc, 16, f3, 1, 2), 1, 0, 0);
    step(req, mk(opc, 3, f3, 17, 2), 1, 0, 0);
    step(req, mk(opc, 3, f3, 1, 31), 1, 0, 0);
    step(req, mk(opc, 15, f3, 15, 15), 1, 0, 0);
  endtask

  task automatic run_formats(string tag);
    sweep({tag, " R3 op"}, OPC_OP, 0);
    sweep({tag, " R3 op32"}, OPC_OP32, 0);
    sweep({tag, " R3 amo"}, OPC_AMO, 2);
    sweep({tag, " R4 opimm"}, OPC_OPIMM, 0);
    sweep({tag, " R4 load"}, OPC_LOAD, 2);
    sweep({tag, " R4 jalr"}, OPC_JALR, 0);
    sweep({tag, " R4 csrrw"}, OPC_SYSTEM, 1);
    sweep({tag, " R5 store"}, OPC_STORE, 2);
    sweep({tag, " R5 branch"}, OPC_BRANCH, 0);
    sweep({tag, " R6 lui"}, OPC_LUI, 0);
    sweep({tag, " R6 jal"}, OPC_JAL, 0);
    sweep({tag, " R7 csrrwi"}, OPC_SYSTEM, 5);
    sweep({tag, " R10 unknown"}, 7'b1111111, 0);
    sweep({tag, " R10 custom"}, 7'b0001011, 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    // R1: reset state
    step("R1 reset", mk(OPC_OP, 20, 0, 20, 20), 1, 0, 0);
    // R2: I base, all formats legal
    run_formats("R2");
    // R9: clear I, new base only next cycle
    step("R9 write", mk(OPC_OP, 16, 0, 1, 1), 1, 1, 0);
    step("R9 after", mk(OPC_OP, 16, 0, 1, 1), 1, 0, 0);
    run_formats("emb");
    // R8: invalid strobe keeps outputs low
    step("R8 idle", mk(OPC_OP, 31, 0, 31, 31), 0, 0, 0);
    step("R8 idle csr", mk(OPC_SYSTEM, 20, 1, 0, 0), 0, 0, 0);
    // R11: embedded-only instance ignores writes
    step("R11 wr", mk(OPC_OP, 1, 0, 1, 1), 1, 1, 0);
    step("R9 set I", mk(OPC_OP, 16, 0, 1, 1), 1, 1, 1);
    step("R9 back I", mk(OPC_OP, 16, 0, 1, 1), 1, 0, 0);
    @(negedge clk);
    instr = mk(OPC_OP, 16, 0, 1, 1); valid = 1'b1; we = 1'b1; wdata = 32'h100;
    #1;
    chk("R11 I fixed", mi_e, 1'b0);
    chk("R11 E fixed", me_e, 1'b1);
    chk("R11 check active", ill_e, 1'b1);
    chk("R11 suppress", sup_e, 1'b1);
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; instr = mk(OPC_LUI, 5, 0, 31, 31);
    #1;
    chk("R11 I after write", mi_e, 1'b0);
    chk("R11 lui legal", ill_e, 1'b0);
    ref_i = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule